// File: doc/BRIEF.md
# Word ECC Controller with Background Scrubber

This block protects 32-bit words held in a byte-wide bulk DRAM array with a single-error-correcting, double-error-detecting code. The lowest three quarters of the array's byte address range hold data. The top quarter holds one check byte per data word. A client writes or reads a whole word through a request port. The controller breaks each request into byte accesses on a simple memory port with a ready handshake. The client is held until the sequence completes, which gives it wait states.

Error correction can be switched off. In that state, words pass through as four raw bytes and the check quarter is never touched. With correction on and scrubbing enabled, the controller uses every idle moment to walk the data region one word at a time. It reads each word, checks it, and rewrites it only when it finds a correctable error. Corrected and uncorrectable events from both clients and the scrubber are counted in saturating counters. The word index of the latest uncorrectable error is kept as well.

Top module: `wecc_scrub_ctrl`

## Requirements
- R1: With correction on, a write makes exactly five byte writes. Byte i of word w (bits 8i+7..8i) goes to byte address 4w+i, for i = 0..3 in ascending order. The check byte follows last, at QBASE+w, where QBASE is three quarters of the array size (192 for an 8-bit address).
- R2: With correction on, reading a word whose bytes are unaltered returns the written value with both error flags low.
- R3: A single flipped bit in any of the four data bytes, or in check-byte bits 0..6, is corrected in the returned data, and the corrected flag is raised.
- R4: Two flipped bits within one word raise the uncorrectable flag and leave the corrected flag low.
- R5: With correction off, a write makes only the four data-byte writes and leaves the check byte unchanged. A read returns the raw bytes with both flags low and no counter change, even when the stored check byte disagrees.
- R6: With correction on, scrubbing enabled and no client request, the scrubber reads words 0,1,2,... in ascending order and wraps to word 0 after the last data word. It rewrites the four data bytes and the check byte of a word only when that word held a correctable error, so memory afterwards holds the corrected bytes.
- R7: A client request pending while the controller is idle is served before any new scrub step. A scrub step already under way finishes first.
- R8: The corrected and uncorrectable counters each advance by one per event, from client reads and scrub steps alike, and hold at their all-ones value.
- R9: The word index of the most recent uncorrectable error is presented on a dedicated output.
- R10: While a memory access waits for ready, its request, direction, address and write byte stay unchanged.
- R11: Each client request that is held until acknowledged produces exactly one single-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Correction enable, sampled when a request starts |
| scrub_en | input | 1 | Background scrub enable (effective only with ecc_en) |
| cl_req | input | 1 | Client request, held until cl_ack |
| cl_we | input | 1 | Client write (1) or read (0) |
| cl_addr | input | ADDR_W-2 | Client word index |
| cl_wdata | input | 32 | Client write word |
| cl_ack | output | 1 | One-cycle completion pulse |
| cl_rdata | output | 32 | Read word, valid with cl_ack |
| cl_corr | output | 1 | Read needed a single-bit correction |
| cl_unc | output | 1 | Read held an uncorrectable error |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| cnt_corr | output | CNT_W | Saturating corrected-error count |
| cnt_unc | output | CNT_W | Saturating uncorrectable-error count |
| last_unc_addr | output | ADDR_W-2 | Word index of latest uncorrectable error |

## Verification
Some rules are checked by assertions on every cycle:
- the memory access stays stable while it waits for ready;
- the acknowledge is a single pulse;
- no access reaches the check quarter with correction off;
- an idle controller facing a client request never starts a scrub step;
- the counters saturate and step correctly;
- the error address is captured.

Other behaviour is shown only by the bench's scenarios, which alter the memory model behind the controller's back:
- whether a flipped bit comes back corrected;
- that two flipped bits are reported;
- that the scrubber repairs stored bytes, writes nothing for clean words and walks in wrapping order.

// File: rtl/wecc_pkg.sv
package wecc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HAM_W    = 6;
  localparam int unsigned CODE_LEN = DATA_W + HAM_W;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_EVAL, ST_RESP} state_t;
  typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_SCRUB} op_t;

  // Codeword position of data bit k: positions 1..CODE_LEN skipping powers of two.
  function automatic logic [HAM_W-1:0] data_pos(input int k);
    int seen;
    logic [HAM_W-1:0] res;
    seen = 0;
    res  = '0;
    for (int p = 1; p <= CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == k) res = HAM_W'(p);
        seen++;
      end
    end
    return res;
  endfunction

  // Hamming check bits: XOR of the positions of all set data bits.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (d[k]) h = h ^ data_pos(k);
    end
    return h;
  endfunction
endpackage

// File: rtl/wecc_codec.sv
module wecc_codec
  import wecc_pkg::*;
(
  input  logic [DATA_W-1:0] enc_data,
  output logic [7:0]        enc_chk,
  input  logic [DATA_W-1:0] dec_data,
  input  logic [HAM_W:0]    dec_chk,
  output logic [DATA_W-1:0] fix_data,
  output logic              err_single,
  output logic              err_double
);
  logic [HAM_W-1:0]  enc_h;
  logic [HAM_W-1:0]  syn;
  logic              par;
  logic [DATA_W-1:0] flip;

  assign enc_h   = ham_bits(enc_data);
  assign enc_chk = {1'b0, ^{enc_data, enc_h}, enc_h};

  assign syn = ham_bits(dec_data) ^ dec_chk[HAM_W-1:0];
  assign par = ^{dec_data, dec_chk};

  generate
    for (genvar k = 0; k < DATA_W; k++) begin : g_fix
      assign flip[k] = par && (syn == data_pos(k));
    end
  endgenerate

  assign fix_data   = dec_data ^ flip;
  assign err_single = par && (int'(syn) <= CODE_LEN);
  assign err_double = (!par && (syn != '0)) || (par && (int'(syn) > CODE_LEN));
endmodule

// File: rtl/wecc_err_log.sv
module wecc_err_log #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WA_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_corr,
  input  logic            hit_unc,
  input  logic [WA_W-1:0] hit_addr,
  output logic [CNT_W-1:0] cnt_corr,
  output logic [CNT_W-1:0] cnt_unc,
  output logic [WA_W-1:0]  last_unc_addr
);
  logic [CNT_W-1:0] corr_q, corr_d, unc_q, unc_d;
  logic [WA_W-1:0]  last_q;

  always_comb begin
    corr_d = (corr_q == '1) ? corr_q : corr_q + 1'b1;
    unc_d  = (unc_q == '1) ? unc_q : unc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      unc_q  <= '0;
      last_q <= '0;
    end else begin
      if (hit_corr) corr_q <= corr_d;
      if (hit_unc) begin
        unc_q  <= unc_d;
        last_q <= hit_addr;
      end
    end
  end

  assign cnt_corr      = corr_q;
  assign cnt_unc       = unc_q;
  assign last_unc_addr = last_q;

  p_corr_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_corr == '1) |=> (cnt_corr == '1));
  p_unc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_unc && cnt_unc != '1) |=> (cnt_unc == $past(cnt_unc) + 1'b1));
  p_last_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_unc |=> (last_unc_addr == $past(hit_addr)));
endmodule

// File: rtl/wecc_scrub_ctrl.sv
module wecc_scrub_ctrl
  import wecc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ecc_en,
  input  logic                scrub_en,
  input  logic                cl_req,
  input  logic                cl_we,
  input  logic [ADDR_W-3:0]   cl_addr,
  input  logic [DATA_W-1:0]   cl_wdata,
  output logic                cl_ack,
  output logic [DATA_W-1:0]   cl_rdata,
  output logic                cl_corr,
  output logic                cl_unc,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata,
  input  logic                mem_rdy,
  output logic [CNT_W-1:0]    cnt_corr,
  output logic [CNT_W-1:0]    cnt_unc,
  output logic [ADDR_W-3:0]   last_unc_addr
);
  localparam int unsigned WA_W       = ADDR_W - 2;
  localparam int unsigned QBASE      = 3 << (ADDR_W - 2);
  localparam int unsigned DATA_WORDS = QBASE / 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  state_t            state_q, state_d;
  op_t               op_q, op_d;
  logic              ecc_q, ecc_d;
  logic [WA_W-1:0]   waddr_q, waddr_d, scrub_q, scrub_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic [DATA_W-1:0] data_q, data_d, rdata_q, rdata_d;
  logic [HAM_W:0]    chk_q, chk_d;
  logic              corr_q, corr_d, unc_q, unc_d;
  logic              log_corr, log_unc, last_beat, chk_beat;

  logic [7:0]        enc_chk;
  logic [DATA_W-1:0] fix_data;
  logic              err_single, err_double;

  wecc_codec u_codec (
    .enc_data  (data_q),
    .enc_chk   (enc_chk),
    .dec_data  (data_q),
    .dec_chk   (chk_q),
    .fix_data  (fix_data),
    .err_single(err_single),
    .err_double(err_double)
  );

  wecc_err_log #(.CNT_W(CNT_W), .WA_W(WA_W)) u_log (
    .clk          (clk),
    .rst_n        (rst_ni),
    .hit_corr     (log_corr),
    .hit_unc      (log_unc),
    .hit_addr     (waddr_q),
    .cnt_corr     (cnt_corr),
    .cnt_unc      (cnt_unc),
    .last_unc_addr(last_unc_addr)
  );

  assign chk_beat  = (bcnt_q == 3'd4);
  assign last_beat = chk_beat || ((bcnt_q == 3'd3) && !ecc_q);

  always_comb begin
    state_d  = state_q;  op_d    = op_q;    ecc_d   = ecc_q;
    waddr_d  = waddr_q;  scrub_d = scrub_q; bcnt_d  = bcnt_q;
    data_d   = data_q;   chk_d   = chk_q;   rdata_d = rdata_q;
    corr_d   = corr_q;   unc_d   = unc_q;
    log_corr = 1'b0;     log_unc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        bcnt_d = '0;
        if (cl_req) begin
          op_d    = cl_we ? OP_WRITE : OP_READ;
          ecc_d   = ecc_en;
          waddr_d = cl_addr;
          data_d  = cl_wdata;
          state_d = cl_we ? ST_WR : ST_RD;
        end else if (ecc_en && scrub_en) begin
          op_d    = OP_SCRUB;
          ecc_d   = 1'b1;
          waddr_d = scrub_q;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (mem_rdy) begin
          if (chk_beat) chk_d = mem_rdata[HAM_W:0];
          else          data_d[8*bcnt_q[1:0] +: 8] = mem_rdata;
          bcnt_d = bcnt_q + 3'd1;
          if (last_beat) begin
            if (ecc_q) state_d = ST_EVAL;
            else begin
              rdata_d = data_d;
              corr_d  = 1'b0;
              unc_d   = 1'b0;
              state_d = ST_RESP;
            end
          end
        end
      end
      ST_WR: begin
        if (mem_rdy) begin
          bcnt_d = bcnt_q + 3'd1;
          if (last_beat) begin
            corr_d  = (op_q == OP_SCRUB) ? corr_q : 1'b0;
            unc_d   = (op_q == OP_SCRUB) ? unc_q : 1'b0;
            state_d = (op_q == OP_SCRUB) ? ST_IDLE : ST_RESP;
          end
        end
      end
      ST_EVAL: begin
        log_corr = err_single;
        log_unc  = err_double;
        if (op_q == OP_SCRUB) begin
          scrub_d = (scrub_q == WA_W'(DATA_WORDS - 1)) ? '0 : scrub_q + 1'b1;
          if (err_single) begin
            data_d  = fix_data;
            bcnt_d  = '0;
            state_d = ST_WR;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          rdata_d = err_double ? data_q : fix_data;
          corr_d  = err_single;
          unc_d   = err_double;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  op_q    <= OP_READ; ecc_q   <= 1'b0;
      waddr_q <= '0;       scrub_q <= '0;      bcnt_q  <= '0;
      data_q  <= '0;       chk_q   <= '0;      rdata_q <= '0;
      corr_q  <= 1'b0;     unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;  op_q    <= op_d;    ecc_q   <= ecc_d;
      waddr_q <= waddr_d;  scrub_q <= scrub_d; bcnt_q  <= bcnt_d;
      data_q  <= data_d;   chk_q   <= chk_d;   rdata_q <= rdata_d;
      corr_q  <= corr_d;   unc_q   <= unc_d;
    end
  end

  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = chk_beat ? (ADDR_W'(QBASE) + ADDR_W'(waddr_q)) : {waddr_q, bcnt_q[1:0]};
  assign mem_wdata = chk_beat ? enc_chk : data_q[8*bcnt_q[1:0] +: 8];
  assign cl_ack    = (state_q == ST_RESP);
  assign cl_rdata  = rdata_q;
  assign cl_corr   = corr_q;
  assign cl_unc    = unc_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    cl_ack |=> !cl_ack);
  p_chk_quarter_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && (int'(mem_addr) >= QBASE)) |-> ecc_q);
  p_client_first_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && cl_req) |=> (op_q != OP_SCRUB));
  p_scrub_range_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(scrub_q) < DATA_WORDS);
endmodule

// File: tb/wecc_scrub_ctrl_test.sv
module wecc_scrub_ctrl_test;
  localparam int AW = 8;
  localparam int CW = 3;
  localparam int QB = 192;
  localparam int NW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1, scrub_en = 1'b0;
  logic cl_req = 1'b0, cl_we = 1'b0;
  logic [AW-3:0] cl_addr = '0;
  logic [31:0] cl_wdata = '0;
  logic cl_ack, cl_corr, cl_unc, mem_req, mem_we;
  logic [31:0] cl_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_rdy = 1'b0;
  logic [CW-1:0] cnt_corr, cnt_unc;
  logic [AW-3:0] last_unc_addr;

  always #5 clk = ~clk;

  wecc_scrub_ctrl #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .scrub_en(scrub_en),
    .cl_req(cl_req), .cl_we(cl_we), .cl_addr(cl_addr), .cl_wdata(cl_wdata),
    .cl_ack(cl_ack), .cl_rdata(cl_rdata), .cl_corr(cl_corr), .cl_unc(cl_unc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .cnt_corr(cnt_corr), .cnt_unc(cnt_unc), .last_unc_addr(last_unc_addr));

  int checks = 0, errors = 0;
  int wr_cnt = 0, b0_reads = 0, order_err = 0, wraps = 0, hold_err = 0, pulse_err = 0;
  int lat = 0, wcnt = 0, prev_w = -1;
  bit order_on = 1'b0, prev_pend = 1'b0, prev_ack = 1'b0, done = 1'b0;
  logic [AW-1:0] last_wa = '0, p_addr = '0;
  logic [7:0] p_wdata = '0;
  logic p_we = 1'b0;
  logic [7:0] mem [0:(1<<AW)-1];

  typedef struct { bit rd; bit cmp; logic [31:0] data; bit corr; bit unc; string tag; } item_t;
  item_t exp_q[$];
  item_t it;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: byte array, ready after a rotating 0..2 cycle latency
  assign mem_rdata = mem[mem_addr];
  always @(negedge clk) begin
    if (!mem_req) begin mem_rdy = 1'b0; wcnt = 0; end
    else if (wcnt >= lat) begin mem_rdy = 1'b1; wcnt = 0; lat = (lat + 1) % 3; end
    else begin mem_rdy = 1'b0; wcnt++; end
  end
  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt++;
        last_wa = mem_addr;
      end else if (int'(mem_addr) < QB && mem_addr[1:0] == 2'b00) begin
        b0_reads++;
        if (order_on) begin
          if (prev_w >= 0 && int'(mem_addr >> 2) != (prev_w + 1) % NW) order_err++;
          if (prev_w >= 0 && mem_addr == 0) wraps++;
          prev_w = int'(mem_addr >> 2);
        end
      end
    end
  end

  // handshake and pulse monitors, scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata))
        hold_err++;
      if (prev_ack && cl_ack) pulse_err++;
      if (cl_ack) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected ack", 32'd1, 32'd0);
        else begin
          it = exp_q.pop_front();
          if (it.rd)
            check((cl_corr == it.corr) && (cl_unc == it.unc) && (!it.cmp || cl_rdata == it.data),
                  it.tag, {cl_corr, cl_unc, cl_rdata[29:0]}, {it.corr, it.unc, it.data[29:0]});
          else
            check(1'b1, it.tag, 32'd0, 32'd0);
        end
      end
    end
    prev_pend = mem_req && !mem_rdy;
    p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
    prev_ack = cl_ack;
  end

  task automatic issue(input bit we, input int a, input logic [31:0] d);
    @(negedge clk);
    cl_req = 1'b1; cl_we = we; cl_addr = (AW-2)'(a); cl_wdata = d;
    do @(negedge clk); while (!cl_ack);
    cl_req = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    exp_q.push_back('{1'b0, 1'b0, d, 1'b0, 1'b0, tag});
    issue(1'b1, a, d);
  endtask

  task automatic rd(input int a, input logic [31:0] d, input bit cmp, input bit c, input bit u, input string tag);
    exp_q.push_back('{1'b1, cmp, d, c, u, tag});
    issue(1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual no completion, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] orig_chk2;
    int w0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cl_ack && !mem_req, "reset R11 idle", {30'd0, cl_ack, mem_req}, 32'd0);
    check(cnt_corr == 0 && cnt_unc == 0, "reset R8 counters", {26'd0, cnt_corr, cnt_unc}, 32'd0);

    // R1 write layout
    w0 = wr_cnt;
    wr(0, 32'h1234_5678, "R1 ack");
    wr(1, 32'hDEAD_BEEF, "R1 ack");
    wr(2, 32'h0F0F_F0F0, "R1 ack");
    wr(3, 32'h8000_0001, "R1 ack");
    check(wr_cnt - w0 == 20, "R1 five writes per word", wr_cnt - w0, 20);
    check(last_wa == AW'(QB + 3), "R1 check byte address last", last_wa, QB + 3);
    check({mem[7], mem[6], mem[5], mem[4]} == 32'hDEAD_BEEF, "R1 byte order",
          {mem[7], mem[6], mem[5], mem[4]}, 32'hDEAD_BEEF);

    // R2 clean reads
    rd(0, 32'h1234_5678, 1, 0, 0, "R2 read word0");
    rd(1, 32'hDEAD_BEEF, 1, 0, 0, "R2 read word1");
    rd(3, 32'h8000_0001, 1, 0, 0, "R2 read word3");

    // R3 single flips in data and check byte
    mem[6] = mem[6] ^ 8'h20;
    rd(1, 32'hDEAD_BEEF, 1, 1, 0, "R3 data bit corrected");
    orig_chk2 = mem[QB + 2];
    mem[QB + 2] = mem[QB + 2] ^ 8'h08;
    rd(2, 32'h0F0F_F0F0, 1, 1, 0, "R3 check bit corrected");
    check(cnt_corr == 2, "R8 corrected count", cnt_corr, 2);

    // R4 double flip
    mem[12] = mem[12] ^ 8'h01;
    mem[14] = mem[14] ^ 8'h80;
    rd(3, 32'h0, 0, 0, 1, "R4 double flagged");
    check(cnt_unc == 1, "R8 unc count", cnt_unc, 1);
    check(last_unc_addr == 3, "R9 last unc addr", last_unc_addr, 3);

    // R5 correction off
    ecc_en = 1'b0;
    w0 = wr_cnt;
    wr(10, 32'hCAFE_0042, "R5 ack");
    check(wr_cnt - w0 == 4, "R5 four writes", wr_cnt - w0, 4);
    check(mem[QB + 10] == 8'h00, "R5 check byte untouched", mem[QB + 10], 0);
    rd(10, 32'hCAFE_0042, 1, 0, 0, "R5 raw read");
    rd(1, 32'hDE8D_BEEF, 1, 0, 0, "R5 raw corrupted read");
    check(cnt_corr == 2 && cnt_unc == 1, "R5 counters unchanged", {cnt_corr, cnt_unc}, {3'd2, 3'd1});
    ecc_en = 1'b1;
    wr(10, 32'hCAFE_0042, "R5 rewrite");
    wr(3, 32'h8000_0001, "R4 rewrite");

    // R6 scrub repairs words 1 and 2
    w0 = wr_cnt;
    scrub_en = 1'b1;
    repeat (1500) @(negedge clk);
    check(mem[6] == 8'hAD, "R6 data byte repaired", mem[6], 8'hAD);
    check(mem[QB + 2] == orig_chk2, "R6 check byte repaired", mem[QB + 2], orig_chk2);
    check(wr_cnt - w0 == 10, "R6 writes only for corrected words", wr_cnt - w0, 10);
    check(cnt_corr == 4, "R8 scrub corrections counted", cnt_corr, 4);

    // R7 client served during scrubbing
    b0_reads = 0;
    rd(2, 32'h0F0F_F0F0, 1, 0, 0, "R7 read during scrub");
    check(b0_reads <= 2, "R7 at most one scrub step before client", b0_reads, 2);
    wr(5, 32'h5555_AAAA, "R7 write during scrub");
    rd(5, 32'h5555_AAAA, 1, 0, 0, "R7 read back during scrub");

    // R8/R9 saturation on a persistent double error, R6 order and wrap
    scrub_en = 1'b0;
    repeat (40) @(negedge clk);
    mem[80] = mem[80] ^ 8'h03;
    order_on = 1'b1;
    scrub_en = 1'b1;
    repeat (12000) @(negedge clk);
    check(cnt_unc == 3'h7, "R8 unc saturates", cnt_unc, 7);
    check(last_unc_addr == 20, "R9 scrub unc addr", last_unc_addr, 20);
    check(order_err == 0, "R6 ascending order", order_err, 0);
    check(wraps >= 2, "R6 wraps to word 0", wraps, 2);
    check(hold_err == 0, "R10 access held until ready", hold_err, 0);
    check(pulse_err == 0, "R11 single-cycle ack", pulse_err, 0);
    check(exp_q.size() == 0, "R11 every request acknowledged", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule